// File: doc/BRIEF.md
# Banked Host Transfer FIFO

This block is a 256-word, 32-bit FIFO that moves data between a host port and an internal engine. Storage is split into four banks of 64 words, and the block reports its state bank by bank rather than word by word. The writer fills one bank at a time and moves on in the fixed order 0, 1, 2, 3, 0. The reader drains the banks in that same order. A bank becomes visible to the reader only once it is closed. A bank closes either when its 64th word is written or earlier, when a word is written with the frame-end marker.

Both sides get a two-bit coarse state. The block also shows a per-bank map of banks that hold unread data and a per-bank map of banks that can take writes. For the bank being read it gives a count of the words still available and a flag that marks the end of a frame. A flush input empties every bank in a single cycle. Bus decoding and the engine that produces or consumes the data sit outside this block.

Top module: `bank_fifo`

## Requirements
- R1: After reset the outputs read as follows. `wrState` and `rdState` are 00, `bankWritable` is 4'b1111, `bankUnread` is 4'b0000, `rdAvail` is 0 and `rdFrameEnd` is 0.
- R2: Words come out on `rdData` in exactly the order they were accepted on the write side, across bank boundaries and around the wrap from bank 3 to bank 0.
- R3: A bank closes by itself when its 64th word is written. Its read side then shows `rdAvail` = 0x3F, meaning 64 words (the count is the number of words left minus one).
- R4: When a word is written with `wrCommit` high, its bank closes after that word. For that bank, `rdAvail` shows the number of words written minus one and `rdFrameEnd` is 1. The next accepted write goes to the following bank.
- R5: Each accepted read lowers `rdAvail` by one. A bank becomes writable again only after its last closed word has been read. At that point the reader moves to the next bank.
- R6: `wrState` has three codes. It is 11 (full) when the writer's current bank is still closed. It is 00 (empty) when no bank is closed and the open bank holds no words. It is 01 (ready) otherwise.
- R7: `rdState` has three codes. It is 00 when the reader's bank is not closed. It is 11 when all four banks are closed. It is 01 otherwise.
- R8: Bit i of `bankWritable` is 1 when bank i is not closed. Bit i of `bankUnread` is 1 when bank i is closed or is the open write bank holding at least one word. Both maps hold their value in any cycle with no write, no read and no flush.
- R9: A write while `wrState` is 11 is dropped, and the word never appears on the read side. A read while `rdState` is 00 is dropped and leaves both pointers unchanged.
- R10: A `flush` returns all outputs to the R1 state in the next cycle. It takes priority over a write or read in the same cycle, and the next write lands in bank 0.
- R11: A write and a read in the same cycle both take effect. When the read releases a bank while the FIFO is full, the write in that same cycle is still dropped. A write in the following cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous flush of all banks |
| wrEn | input | 1 | Write request |
| wrData | input | 32 | Write word |
| wrCommit | input | 1 | Frame-end marker on this write; closes the bank |
| rdEn | input | 1 | Read request (consumes `rdData`) |
| rdData | output | 32 | Word at the head of the reader's bank |
| wrState | output | 2 | Write-side coarse state: 00 empty, 01 ready, 11 full |
| rdState | output | 2 | Read-side coarse state: 00 empty, 01 ready, 11 full |
| bankUnread | output | 4 | Per-bank map of banks holding unread words |
| bankWritable | output | 4 | Per-bank map of banks that can accept writes |
| rdAvail | output | 6 | Words left in the reader's bank, minus one |
| rdFrameEnd | output | 1 | Reader's bank ends a frame |

## Verification
Two events can land on the same edge: the read that drains the last word of a bank, and a write arriving while all four banks are closed. The bench fills the FIFO completely, reads down to the final word of the head bank, and then raises `wrEn` and `rdEn` together. It checks that the read word is correct, that exactly that bank turns writable, and that the colliding word is absent from the later read stream while a write one cycle later is present. A second collision, a read and a write together on different banks in mid-bank, is judged the same way through the order of the drained data.

// File: rtl/bank_fifo_pkg.sv
package bank_fifo_pkg;
  // Strobes sent from the control to the storage datapath
  typedef struct packed {
    logic wrStb;
    logic rdStb;
  } memStrobeT;

  // Coarse state codes (both sides)
  typedef enum logic [1:0] {
    ST_EMPTY = 2'b00,
    ST_READY = 2'b01,
    ST_FULL  = 2'b11
  } fifoStateE;
endpackage

// File: rtl/bank_fifo_store.sv
module bank_fifo_store
  import bank_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  memStrobeT         strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.wrStb) mem[wrAddr] <= wrData;
  end

  // Head word is presented combinationally; rdStb only advances the control
  assign rdData = mem[rdAddr];
endmodule

// File: rtl/bank_fifo_ctrl.sv
module bank_fifo_ctrl
  import bank_fifo_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_DEPTH = 64,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int OFF_W  = $clog2(BANK_DEPTH),
  localparam int ADDR_W = BANK_W + OFF_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flush,
  input  logic                 wrEn,
  input  logic                 wrCommit,
  input  logic                 rdEn,
  output memStrobeT            strb,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic [ADDR_W-1:0]    rdAddr,
  output logic [1:0]           wrState,
  output logic [1:0]           rdState,
  output logic [NUM_BANKS-1:0] bankUnread,
  output logic [NUM_BANKS-1:0] bankWritable,
  output logic [OFF_W-1:0]     rdAvail,
  output logic                 rdFrameEnd
);
  logic [BANK_W-1:0]    wrBank, rdBank;
  logic [OFF_W-1:0]     wrOff, rdOff;
  logic [NUM_BANKS-1:0] closed;
  logic [NUM_BANKS-1:0] bankEof;
  logic [OFF_W-1:0]     bankLast [NUM_BANKS];

  logic wrOk, rdOk, wrAcc, rdAcc, wrClose, rdClose;

  function automatic logic [BANK_W-1:0] nextBank(input logic [BANK_W-1:0] b);
    return (b == BANK_W'(NUM_BANKS - 1)) ? '0 : b + 1'b1;
  endfunction

  assign wrOk    = ~closed[wrBank];
  assign rdOk    = closed[rdBank];
  assign wrAcc   = wrEn & wrOk & ~flush;
  assign rdAcc   = rdEn & rdOk & ~flush;
  assign wrClose = wrAcc & (wrCommit | (wrOff == OFF_W'(BANK_DEPTH - 1)));
  assign rdClose = rdAcc & (rdOff == bankLast[rdBank]);

  assign strb.wrStb = wrAcc;
  assign strb.rdStb = rdAcc;
  assign wrAddr = {wrBank, wrOff};
  assign rdAddr = {rdBank, rdOff};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrBank  <= '0;
      rdBank  <= '0;
      wrOff   <= '0;
      rdOff   <= '0;
      closed  <= '0;
      bankEof <= '0;
      for (int i = 0; i < NUM_BANKS; i++) bankLast[i] <= '0;
    end else if (flush) begin
      wrBank  <= '0;
      rdBank  <= '0;
      wrOff   <= '0;
      rdOff   <= '0;
      closed  <= '0;
      bankEof <= '0;
    end else begin
      if (wrAcc) begin
        if (wrClose) begin
          closed[wrBank]   <= 1'b1;
          bankLast[wrBank] <= wrOff;
          bankEof[wrBank]  <= wrCommit;
          wrBank           <= nextBank(wrBank);
          wrOff            <= '0;
        end else begin
          wrOff <= wrOff + 1'b1;
        end
      end
      if (rdAcc) begin
        if (rdClose) begin
          closed[rdBank] <= 1'b0;
          rdBank         <= nextBank(rdBank);
          rdOff          <= '0;
        end else begin
          rdOff <= rdOff + 1'b1;
        end
      end
    end
  end

  // Per-bank maps
  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBankMap
    assign bankWritable[g] = ~closed[g];
    assign bankUnread[g]   = closed[g] | ((wrBank == BANK_W'(g)) & (wrOff != '0));
  end

  // Coarse states
  fifoStateE wrSt, rdSt;
  always_comb begin
    if (!wrOk)                        wrSt = ST_FULL;
    else if (~|closed && wrOff == '0) wrSt = ST_EMPTY;
    else                              wrSt = ST_READY;
    if (!rdOk)          rdSt = ST_EMPTY;
    else if (&closed)   rdSt = ST_FULL;
    else                rdSt = ST_READY;
  end
  assign wrState    = wrSt;
  assign rdState    = rdSt;
  assign rdAvail    = rdOk ? (bankLast[rdBank] - rdOff) : '0;
  assign rdFrameEnd = rdOk & bankEof[rdBank];

  // Assertions
  assert_state_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrState != 2'b10) && (rdState != 2'b10));

  assert_full_agree_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrState == 2'b11) == (rdState == 2'b11));

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (wrState == 2'b00) && (rdState == 2'b00) && (bankUnread == '0)
              && (&bankWritable));

  assert_idle_maps_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !rdEn && !flush) |=> $stable(bankUnread) && $stable(bankWritable)
                                   && $stable(rdAvail));

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && !flush && rdState == 2'b00) |=> (rdState == 2'b00)
                                                      && $stable(bankUnread));

  assert_avail_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !flush && rdState != 2'b00 && rdAvail != '0)
      |=> rdAvail == $past(rdAvail) - OFF_W'(1));
endmodule

// File: rtl/bank_fifo.sv
module bank_fifo
  import bank_fifo_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_BANKS  = 4,
  parameter int BANK_DEPTH = 64,
  localparam int OFF_W  = $clog2(BANK_DEPTH),
  localparam int ADDR_W = $clog2(NUM_BANKS) + OFF_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flush,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 wrCommit,
  input  logic                 rdEn,
  output logic [DATA_W-1:0]    rdData,
  output logic [1:0]           wrState,
  output logic [1:0]           rdState,
  output logic [NUM_BANKS-1:0] bankUnread,
  output logic [NUM_BANKS-1:0] bankWritable,
  output logic [OFF_W-1:0]     rdAvail,
  output logic                 rdFrameEnd
);
  memStrobeT         strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  bank_fifo_ctrl #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_DEPTH(BANK_DEPTH)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .flush       (flush),
    .wrEn        (wrEn),
    .wrCommit    (wrCommit),
    .rdEn        (rdEn),
    .strb        (strb),
    .wrAddr      (wrAddr),
    .rdAddr      (rdAddr),
    .wrState     (wrState),
    .rdState     (rdState),
    .bankUnread  (bankUnread),
    .bankWritable(bankWritable),
    .rdAvail     (rdAvail),
    .rdFrameEnd  (rdFrameEnd)
  );

  bank_fifo_store #(
    .DATA_W(DATA_W),
    .DEPTH (NUM_BANKS * BANK_DEPTH)
  ) uStore (
    .clk   (clk),
    .strb  (strb),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdAddr(rdAddr),
    .rdData(rdData)
  );
endmodule

// File: tb/tb_bank_fifo.sv
module tb_bank_fifo;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        wrCommit = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic [1:0]  wrState, rdState;
  logic [3:0]  bankUnread, bankWritable;
  logic [5:0]  rdAvail;
  logic        rdFrameEnd;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;
  logic [31:0] expQ[$];

  always #5 clk = ~clk;

  bank_fifo dut (
    .clk(clk), .rstN(rstN), .flush(flush), .wrEn(wrEn), .wrData(wrData),
    .wrCommit(wrCommit), .rdEn(rdEn), .rdData(rdData), .wrState(wrState),
    .rdState(rdState), .bankUnread(bankUnread), .bankWritable(bankWritable),
    .rdAvail(rdAvail), .rdFrameEnd(rdFrameEnd)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chkEq(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, what, act, exp);
  endtask

  task automatic chkMaps(input string req, input logic [1:0] ws, input logic [1:0] rs,
                         input logic [3:0] un, input logic [3:0] wb);
    chkEq(req, "wrState", 32'(wrState), 32'(ws));
    chkEq(req, "rdState", 32'(rdState), 32'(rs));
    chkEq(req, "bankUnread", 32'(bankUnread), 32'(un));
    chkEq(req, "bankWritable", 32'(bankWritable), 32'(wb));
  endtask

  // Push one word; accepted words join the expected queue
  task automatic pushWord(input logic [31:0] d, input bit commit, input bit accepted);
    wrEn = 1'b1; wrData = d; wrCommit = commit;
    tick();
    wrEn = 1'b0; wrCommit = 1'b0;
    if (accepted) expQ.push_back(d);
  endtask

  // Pop one word, comparing the head before the consuming edge (R2)
  task automatic popWord();
    logic [31:0] e;
    e = expQ.pop_front();
    chkEq("R2", "rdData order", rdData, e);
    rdEn = 1'b1;
    tick();
    rdEn = 1'b0;
  endtask

  task automatic testReset();
    chkMaps("R1", 2'b00, 2'b00, 4'b0000, 4'b1111);
    chkEq("R1", "rdAvail", 32'(rdAvail), 0);
    chkEq("R1", "rdFrameEnd", 32'(rdFrameEnd), 0);
  endtask

  task automatic testFullBank();
    for (int i = 0; i < 63; i++) pushWord(32'h1000_0000 + i, 1'b0, 1'b1);
    chkMaps("R8", 2'b01, 2'b00, 4'b0001, 4'b1111); // partial bank unread, not readable
    pushWord(32'h1000_003F, 1'b0, 1'b1);
    chkMaps("R3", 2'b01, 2'b01, 4'b0001, 4'b1110);
    chkEq("R3", "rdAvail 64 words", 32'(rdAvail), 32'h3F);
    chkEq("R3", "rdFrameEnd", 32'(rdFrameEnd), 0);
  endtask

  task automatic testPartial();
    for (int i = 0; i < 4; i++) pushWord(32'h2000_0000 + i, 1'b0, 1'b1);
    pushWord(32'h2000_0004, 1'b1, 1'b1);
    chkMaps("R4", 2'b01, 2'b01, 4'b0011, 4'b1100);
    for (int i = 0; i < 10; i++) popWord();
    chkEq("R5", "rdAvail after 10 reads", 32'(rdAvail), 53);
    for (int i = 0; i < 53; i++) popWord();
    chkEq("R5", "bank0 held before last word", 32'(bankWritable), 32'b1100);
    popWord();
    chkEq("R5", "bank0 released", 32'(bankWritable), 32'b1101);
    chkEq("R4", "rdAvail partial bank", 32'(rdAvail), 4);
    chkEq("R4", "rdFrameEnd", 32'(rdFrameEnd), 1);
    for (int i = 0; i < 5; i++) popWord();
    chkMaps("R6", 2'b00, 2'b00, 4'b0000, 4'b1111);
  endtask

  task automatic testEmptyRead();
    rdEn = 1'b1;
    tick();
    rdEn = 1'b0;
    chkMaps("R9", 2'b00, 2'b00, 4'b0000, 4'b1111);
    chkEq("R9", "rdAvail after empty read", 32'(rdAvail), 0);
    pushWord(32'h3000_00AA, 1'b1, 1'b1);         // lands in bank 2
    chkEq("R4", "single-word rdAvail", 32'(rdAvail), 0);
    chkEq("R8", "bank2 unread", 32'(bankUnread), 32'b0100);
    popWord();                                    // R9: pointer did not move
    chkEq("R7", "rdState empty", 32'(rdState), 0);
  endtask

  task automatic testFillAndCollide();
    for (int i = 0; i < 256; i++) pushWord(32'h4000_0000 + i, 1'b0, 1'b1);
    chkMaps("R7", 2'b11, 2'b11, 4'b1111, 4'b0000);
    pushWord(32'hDEAD_BEEF, 1'b0, 1'b0);         // R9: dropped
    chkMaps("R9", 2'b11, 2'b11, 4'b1111, 4'b0000);
    for (int i = 0; i < 63; i++) popWord();
    // R11: release of bank 3 collides with a write while full
    begin
      logic [31:0] e;
      e = expQ.pop_front();
      chkEq("R11", "rdData at release", rdData, e);
      rdEn = 1'b1; wrEn = 1'b1; wrData = 32'h5555_0001;
      tick();
      rdEn = 1'b0; wrEn = 1'b0;
    end
    chkMaps("R11", 2'b01, 2'b01, 4'b0111, 4'b1000);
    pushWord(32'h5555_0002, 1'b0, 1'b1);
    chkEq("R11", "write after release", 32'(bankUnread), 32'b1111);
    // R11: mid-bank read and write together
    begin
      logic [31:0] e;
      e = expQ.pop_front();
      chkEq("R11", "rdData concurrent", rdData, e);
      rdEn = 1'b1; wrEn = 1'b1; wrData = 32'h5555_0003;
      tick();
      rdEn = 1'b0; wrEn = 1'b0;
      expQ.push_back(32'h5555_0003);
    end
    chkEq("R5", "rdAvail concurrent", 32'(rdAvail), 62);
    while (expQ.size() > 2) popWord();
    chkMaps("R7", 2'b01, 2'b00, 4'b1000, 4'b1111);
    pushWord(32'h5555_0004, 1'b1, 1'b1);
    chkEq("R4", "rdAvail 3 words", 32'(rdAvail), 2);
    while (expQ.size() > 0) popWord();
    chkMaps("R6", 2'b00, 2'b00, 4'b0000, 4'b1111);
  endtask

  task automatic testFlush();
    for (int i = 0; i < 70; i++) pushWord(32'h6000_0000 + i, 1'b0, 1'b1);
    flush = 1'b1; wrEn = 1'b1; rdEn = 1'b1; wrData = 32'h7777_7777;
    tick();
    flush = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    expQ.delete();
    chkMaps("R10", 2'b00, 2'b00, 4'b0000, 4'b1111);
    chkEq("R10", "rdAvail", 32'(rdAvail), 0);
    chkEq("R10", "rdFrameEnd", 32'(rdFrameEnd), 0);
    pushWord(32'h8888_0001, 1'b1, 1'b1);
    chkEq("R10", "lands in bank 0", 32'(bankUnread), 32'b0001);
    popWord();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick();
    testReset();
    testFullBank();
    testPartial();
    testEmptyRead();
    testFillAndCollide();
    testFlush();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule